// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary loop of five codes, one step per clock on which counting is enabled. It has no output decoding: the three state flops drive the output pins directly. The five states in the loop are named S_ZERO (000), S_TWO (010), S_THREE (011), S_FIVE (101) and S_SIX (110). The named transitions are zero-to-two, two-to-three, three-to-five, five-to-six, and the wrap from six back to zero.

The three codes outside the loop are S_STRAY_1 (001), S_STRAY_4 (100) and S_STRAY_7 (111). A register can wake up holding one of them. Each of them has an explicit recovery transition to S_ZERO on the next enabled clock, so no start-up value can trap the counter in a loop of unused codes. A synchronous reset also returns the counter to S_ZERO.

The parameter `POWERUP_CODE` sets the value the state register holds before its first clock edge. It models the start-up contents of the register.

Top module: `cyc5_counter`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `q` becomes 000 after that edge, whatever `cnt_en` is.
- R2: With `rst` low and `cnt_en` high, each rising edge advances `q` along 000 → 010 → 011 → 101 → 110 → 000.
- R3: With `rst` low and `cnt_en` low, `q` keeps its value across the edge. This applies to every code, including 001, 100 and 111.
- R4: With `rst` low and `cnt_en` high, any of the unused codes 001, 100 or 111 goes to 000 at the next edge.
- R5: Starting from any power-up code, one enabled edge puts `q` in the loop. Once `q` is in the loop, no edge ever takes it out.
- R6: Before the first clock edge, `q` equals the `POWERUP_CODE` parameter, bit for bit (bit 2 is the most significant bit).
- R7: Starting at 000, exactly five enabled edges bring `q` back to 000. Within those five edges, each loop code appears once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, forces 000 |
| cnt_en | input | 1 | Count enable; when low the state holds |
| q | output | 3 | Current state code, driven straight from the flops |

## Verification
The bench builds one instance with the default `POWERUP_CODE` of 000 and drives its reset and enable. It builds three more instances with `POWERUP_CODE` set to 001, 100 and 111, which never see a reset. These three are the only way to put the unused codes on the pins through the normal interface. That brings the hold-while-disabled behaviour of an unused code and its one-edge recovery within reach. A seeded random run on the reset-driven instance mixes enable gaps and reset pulses into long stretches of the loop.

// File: rtl/cyc5_pkg.sv
package cyc5_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        S_ZERO    = 3'b000,
        S_STRAY_1 = 3'b001,
        S_TWO     = 3'b010,
        S_THREE   = 3'b011,
        S_STRAY_4 = 3'b100,
        S_FIVE    = 3'b101,
        S_SIX     = 3'b110,
        S_STRAY_7 = 3'b111
    } cyc_state_e;

endpackage

// File: rtl/cyc5_next_state.sv
module cyc5_next_state
    import cyc5_pkg::*;
(
    input  cyc_state_e cur,
    output cyc_state_e nxt
);

    always_comb begin
        unique case (cur)
            S_ZERO:    nxt = S_TWO;     // zero-to-two
            S_TWO:     nxt = S_THREE;   // two-to-three
            S_THREE:   nxt = S_FIVE;    // three-to-five
            S_FIVE:    nxt = S_SIX;     // five-to-six
            S_SIX:     nxt = S_ZERO;    // wrap
            S_STRAY_1: nxt = S_ZERO;    // recovery
            S_STRAY_4: nxt = S_ZERO;    // recovery
            S_STRAY_7: nxt = S_ZERO;    // recovery
            default:   nxt = S_ZERO;
        endcase
    end

endmodule

// File: rtl/cyc5_state_reg.sv
module cyc5_state_reg
    import cyc5_pkg::*;
#(
    parameter logic [STATE_W-1:0] POWERUP_CODE = 3'b000
)
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  cyc_state_e nxt,
    output cyc_state_e cur
);

    cyc_state_e state_q = cyc_state_e'(POWERUP_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_ZERO;
        end else if (en) begin
            state_q <= nxt;
        end
    end

    assign cur = state_q;

endmodule

// File: rtl/cyc5_out_map.sv
module cyc5_out_map
    import cyc5_pkg::*;
(
    input  cyc_state_e             cur,
    output logic [STATE_W-1:0]     code
);

    always_comb begin
        code = cur;
    end

endmodule

// File: rtl/cyc5_counter.sv
module cyc5_counter
    import cyc5_pkg::*;
#(
    parameter logic [STATE_W-1:0] POWERUP_CODE = 3'b000
)
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    output logic [STATE_W-1:0] q
);

    cyc_state_e cur_state;
    cyc_state_e nxt_state;

    cyc5_next_state u_next (
        .cur (cur_state),
        .nxt (nxt_state)
    );

    cyc5_state_reg #(
        .POWERUP_CODE (POWERUP_CODE)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (cnt_en),
        .nxt (nxt_state),
        .cur (cur_state)
    );

    cyc5_out_map u_out (
        .cur  (cur_state),
        .code (q)
    );

endmodule

// File: rtl/cyc5_counter_chk.sv
module cyc5_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic [2:0] q
);

    function automatic logic unused_code(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b100) || (c == 3'b111);
    endfunction

    function automatic logic [2:0] loop_succ(input logic [2:0] c);
        case (c)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    AST_RESET_ZERO: assert property (@(posedge clk) $fell(rst) |-> q == 3'b000); // R1
    AST_LOOP_ORDER: assert property (@(posedge clk) disable iff (rst) (cnt_en && !unused_code(q)) |=> q == loop_succ($past(q))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(q)); // R3
    AST_STRAY_RECOVER: assert property (@(posedge clk) disable iff (rst) (cnt_en && unused_code(q)) |=> q == 3'b000); // R4
    AST_STAY_IN_LOOP: assert property (@(posedge clk) disable iff (rst) !unused_code(q) |=> !unused_code(q)); // R5

endmodule

bind cyc5_counter cyc5_counter_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .q      (q)
);

// File: tb/cyc5_counter_tb.sv
module cyc5_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       en_s = 1'b0;
    logic       rst_off = 1'b0;
    logic [2:0] q;
    logic [2:0] q_p1;
    logic [2:0] q_p4;
    logic [2:0] q_p7;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cyc5_counter u_dut (.clk(clk), .rst(rst), .cnt_en(en), .q(q));
    cyc5_counter #(.POWERUP_CODE(3'b001)) u_p1 (.clk(clk), .rst(rst_off), .cnt_en(en_s), .q(q_p1));
    cyc5_counter #(.POWERUP_CODE(3'b100)) u_p4 (.clk(clk), .rst(rst_off), .cnt_en(en_s), .q(q_p4));
    cyc5_counter #(.POWERUP_CODE(3'b111)) u_p7 (.clk(clk), .rst(rst_off), .cnt_en(en_s), .q(q_p7));

    function automatic logic [2:0] model_next(input logic [2:0] s, input logic r, input logic e);
        if (r) return 3'b000;
        if (!e) return s;
        case (s)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic r, input logic e, input logic es);
        @(negedge clk);
        rst = r;
        en = e;
        en_s = es;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] exp;
        void'($urandom(32'd1234));
        exp = 3'b000;

        #1;
        chk("R6 power-up 001", q_p1, 3'b001);
        chk("R6 power-up 100", q_p4, 3'b100);
        chk("R6 power-up 111", q_p7, 3'b111);

        // R1: reset with enable high still forces 000
        tick(1'b1, 1'b1, 1'b0);
        chk("R1 reset overrides enable", q, 3'b000);
        // R3: unused codes hold while disabled
        chk("R3 hold 001", q_p1, 3'b001);
        chk("R3 hold 100", q_p4, 3'b100);
        chk("R3 hold 111", q_p7, 3'b111);
        tick(1'b1, 1'b0, 1'b0);
        chk("R3 hold 111 second edge", q_p7, 3'b111);

        // R4 and R5: one enabled edge recovers
        tick(1'b0, 1'b0, 1'b1);
        chk("R3 hold 000 disabled", q, 3'b000);
        chk("R4 recover 001", q_p1, 3'b000);
        chk("R4 recover 100", q_p4, 3'b000);
        chk("R4 recover 111", q_p7, 3'b000);
        tick(1'b0, 1'b0, 1'b1);
        chk("R5 in loop after recovery", q_p7, 3'b010);

        // R2 and R7: full loop of five enabled edges
        tick(1'b0, 1'b1, 1'b0);
        chk("R2 step 000->010", q, 3'b010);
        tick(1'b0, 1'b1, 1'b0);
        chk("R2 step 010->011", q, 3'b011);
        tick(1'b0, 1'b0, 1'b0);
        chk("R3 hold 011", q, 3'b011);
        tick(1'b0, 1'b1, 1'b0);
        chk("R2 step 011->101", q, 3'b101);
        tick(1'b0, 1'b1, 1'b0);
        chk("R2 step 101->110", q, 3'b110);
        tick(1'b0, 1'b1, 1'b0);
        chk("R7 wrap to 000 after five", q, 3'b000);

        // R1: reset in mid-loop
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        chk("R1 reset from 010", q, 3'b000);

        // random mix against the model
        exp = 3'b000;
        for (int i = 0; i < 400; i++) begin
            logic r;
            logic e;
            r = ($urandom % 24) == 0;
            e = ($urandom % 4) != 0;
            exp = model_next(exp, r, e);
            tick(r, e, 1'b1);
            chk("R2 random run", q, exp);
            if (q == 3'b001 || q == 3'b100 || q == 3'b111)
                chk("R5 stays in loop", q, 3'b000);
        end

        finish_run();
    end

endmodule